// File: doc/BRIEF.md
# Split-Accumulation Transposed FIR Filter

This block is a linear-phase FIR filter built in transposed form. Every accepted sample is multiplied by a fixed set of symmetric coefficients. The products are summed along a chain of adders and registers. Taps are numbered from the output adder (tap 0) toward the input (tap NTAP-1). Only the distinct half of the products is formed, and each one drives both of its mirror taps. The chain itself keeps its full length.

At tap SPLIT, the full-width partial sum that leaves the register feeding that tap is cut in two. The low field has the width of one product and is read as an unsigned value. It continues through a set of narrowed adders and registers down to tap 0. The high field is the signed remainder. It waits in a delay line that is exactly SPLIT stages deep, so it rejoins the low result of the same sample. A single merge adder then adds the high field back at its original bit weight. The result is bit-exact to an unsplit full-width filter. Coefficients, tap count and split position are fixed at elaboration.

Both stream edges use valid/ready. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. Only a taken sample moves the chain. The result sits in an output register. It stays unchanged while `out_valid` is high and `out_ready` is low, and no new sample is taken during that time.

Top module: `split_fir`

## Requirements
- R1: A synchronous reset clears every chain register, the high-field delay line and `out_valid`. Results after reset are computed as if all earlier samples were zero.
- R2: For accepted sample n, `out_data` equals the full-precision signed sum of h(i)·x[n-i] over i = 0..NTAP-1. Samples taken before the last reset count as zero.
- R3: The coefficients are symmetric, h(i) = h(NTAP-1-i). `COEFS` holds only h(0)..h(ceil(NTAP/2)-1), each CW bits in two's complement, with h(k) at bits [k·CW +: CW]. An impulse therefore produces the full mirrored response.
- R4: Each product is CW+DW-1 bits wide. This is exact for every input, including the most negative sample, because no coefficient may use the most negative CW-bit code.
- R5: SPLIT lies in 1..NTAP-2. At that tap the partial sum is divided into a low field of CW+DW-1 bits, read as unsigned, and a signed high field made of the remaining upper bits.
- R6: The narrowed adder at tap i (i ≤ SPLIT) is CW+DW-1+clog2(SPLIT-i+3) bits wide. This width grows toward the output, and the adders never overflow for any input sequence, including sustained full-scale input of either sign.
- R7: The high field passes through exactly SPLIT register stages. It is added at weight 2^(CW+DW-1) to the sign-extended tap-0 low result. The output is correct for any split position.
- R8: `out_valid` is high in the cycle after a sample is taken. It goes low after an edge where `out_ready` is high and no sample is taken.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` stay unchanged.
- R10: A cycle in which no sample is taken leaves the filter state unchanged. Gaps in `in_valid` therefore do not change any later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | CW+DW-1+clog2(NTAP) | Signed full-precision filter output |

## Verification
The bench builds three instances that share the same stimulus and handshake. The first has 24 taps, 6-bit coefficients and a split at tap 9; this puts the long full-width section and a nine-stage delay line in play. The other two have 7 taps and 5-bit coefficients, with splits at 1 and at 5. These reach both ends of the allowed split range and an odd tap count with an unmirrored centre tap. Sustained inputs of -128 and +127 push the narrowed adders to their bounds. Random back-pressure and input gaps exercise the stall and hold rules.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  // Width of the narrowed adder at tap `tap`, for a chain cut at `split`
  // with product width `pw`. Covers an unsigned pw-bit low field plus
  // (split-tap+1) signed products without overflow.
  function automatic int lo_width(input int pw, input int split, input int tap);
    return pw + $clog2(split - tap + 3);
  endfunction
endpackage

// File: rtl/sfir_products.sv
module sfir_products #(
  parameter int NTAP  = 24,
  parameter int DW    = 8,
  parameter int CW    = 6,
  parameter int SPLIT = 9,
  parameter logic [((NTAP+1)/2)*CW-1:0] COEFS = '0
) (
  input  logic signed [DW-1:0]                    x,
  output logic [(SPLIT+1)*(CW+DW-1)-1:0]          q_lo,
  output logic [(NTAP-1-SPLIT)*(CW+DW-1)-1:0]     q_hi
);
  localparam int PW    = CW + DW - 1;
  localparam int NHALF = (NTAP + 1) / 2;

  logic signed [PW-1:0] prod [NHALF];

  // one multiplier per distinct coefficient
  for (genvar k = 0; k < NHALF; k++) begin : g_mul
    localparam logic signed [CW-1:0] HK = COEFS[k*CW +: CW];
    if (HK == {1'b1, {(CW-1){1'b0}}}) begin : g_bad
      $error("coefficient %0d uses the most negative code", k);
    end
    assign prod[k] = PW'(x) * PW'(HK);
  end

  // fan each product to both mirror taps
  for (genvar i = 0; i < NTAP; i++) begin : g_fan
    localparam int M = (i < NHALF) ? i : (NTAP - 1 - i);
    if (i <= SPLIT) begin : g_low
      assign q_lo[i*PW +: PW] = prod[M];
    end else begin : g_high
      assign q_hi[(i-SPLIT-1)*PW +: PW] = prod[M];
    end
  end
endmodule

// File: rtl/sfir_upper.sv
module sfir_upper #(
  parameter int NTAP  = 24,
  parameter int PW    = 13,
  parameter int W     = 18,
  parameter int SPLIT = 9
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            adv,
  input  logic [(NTAP-1-SPLIT)*PW-1:0]    q_hi,
  output logic signed [W-1:0]             pj
);
  // full-width registers for taps SPLIT .. NTAP-2
  logic signed [W-1:0] acc [SPLIT:NTAP-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = SPLIT; i <= NTAP-2; i++) acc[i] <= '0;
    end else if (adv) begin
      acc[NTAP-2] <= W'($signed(q_hi[(NTAP-2-SPLIT)*PW +: PW]));
      for (int i = SPLIT; i <= NTAP-3; i++)
        acc[i] <= acc[i+1] + W'($signed(q_hi[(i-SPLIT)*PW +: PW]));
    end
  end

  assign pj = acc[SPLIT];

  // R10
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pj));
endmodule

// File: rtl/sfir_lower.sv
module sfir_lower #(
  parameter int PW    = 13,
  parameter int W     = 18,
  parameter int SPLIT = 9
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic signed [W-1:0]          pj,
  input  logic [(SPLIT+1)*PW-1:0]      q_lo,
  output logic signed [W-1:0]          y
);
  import sfir_pkg::*;
  localparam int LW = PW;
  localparam int HW = W - LW;
  localparam int MW = lo_width(PW, SPLIT, 0);
  localparam int XW = ((W > MW) ? W : MW) + 1;

  logic [LW-1:0]        lo_f;
  logic signed [HW-1:0] hi_f;
  assign lo_f = pj[LW-1:0];
  assign hi_f = pj[W-1:LW];

  logic signed [MW-1:0] a_bus [SPLIT+1];

  for (genvar i = 0; i <= SPLIT; i++) begin : g_st
    localparam int AW = lo_width(PW, SPLIT, i);
    logic signed [AW-1:0] p_in;
    logic signed [AW-1:0] a_out;
    if (i == SPLIT) begin : g_head
      assign p_in = AW'({1'b0, lo_f});
    end else begin : g_reg
      localparam int RW = lo_width(PW, SPLIT, i + 1);
      logic signed [RW-1:0] r_q;
      always_ff @(posedge clk) begin
        if (rst)      r_q <= '0;
        else if (adv) r_q <= RW'(a_bus[i+1]);
      end
      assign p_in = AW'(r_q);
    end
    assign a_out    = p_in + AW'($signed(q_lo[i*PW +: PW]));
    assign a_bus[i] = MW'(a_out);
  end

  // high field delay line, SPLIT stages
  logic signed [HW-1:0] hd [SPLIT];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SPLIT; k++) hd[k] <= '0;
    end else if (adv) begin
      hd[0] <= hi_f;
      for (int k = 1; k < SPLIT; k++) hd[k] <= hd[k-1];
    end
  end

  assign y = W'((XW'(hd[SPLIT-1]) <<< LW) + XW'(a_bus[0]));

  // R7
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hd[SPLIT-1]));
endmodule

// File: rtl/split_fir.sv
module split_fir #(
  parameter int NTAP  = 24,
  parameter int DW    = 8,
  parameter int CW    = 6,
  parameter int SPLIT = 9,
  parameter logic [((NTAP+1)/2)*CW-1:0] COEFS =
    {6'h1F, 6'h08, 6'h35, 6'h3C, 6'h04, 6'h06,
     6'h03, 6'h3F, 6'h3D, 6'h3E, 6'h00, 6'h01}
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic signed [DW-1:0]                    in_data,
  output logic                                    out_valid,
  input  logic                                    out_ready,
  output logic signed [CW+DW-1+$clog2(NTAP)-1:0]  out_data
);
  localparam int PW = CW + DW - 1;
  localparam int W  = PW + $clog2(NTAP);

  if (SPLIT < 1 || SPLIT > NTAP - 2) begin : g_bad_split
    $error("SPLIT must lie in 1..NTAP-2");
  end

  logic adv;
  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  logic [(SPLIT+1)*PW-1:0]        q_lo;
  logic [(NTAP-1-SPLIT)*PW-1:0]   q_hi;
  logic signed [W-1:0]            pj;
  logic signed [W-1:0]            y;

  sfir_products #(.NTAP(NTAP), .DW(DW), .CW(CW), .SPLIT(SPLIT), .COEFS(COEFS))
    u_prod (.x(in_data), .q_lo(q_lo), .q_hi(q_hi));

  sfir_upper #(.NTAP(NTAP), .PW(PW), .W(W), .SPLIT(SPLIT))
    u_upper (.clk(clk), .rst(rst), .adv(adv), .q_hi(q_hi), .pj(pj));

  sfir_lower #(.PW(PW), .W(W), .SPLIT(SPLIT))
    u_lower (.clk(clk), .rst(rst), .adv(adv), .pj(pj), .q_lo(q_lo), .y(y));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_data  <= y;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);
  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R8
  idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && out_ready) |=> !out_valid);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/tb_split_fir.sv
module tb_split_fir;
  logic clk = 1'b0;
  always #10ns clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [7:0] in_data = '0;
  logic rdy_a, rdy_b, rdy_c, ov_a, ov_b, ov_c;
  logic signed [17:0] od_a;
  logic signed [14:0] od_b, od_c;

  localparam logic [19:0] CB = {5'h0F, 5'h09, 5'h05, 5'h1D};

  split_fir dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(in_data), .out_valid(ov_a), .out_ready(out_ready), .out_data(od_a));
  split_fir #(.NTAP(7), .DW(8), .CW(5), .SPLIT(1), .COEFS(CB)) dut_lo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(in_data), .out_valid(ov_b), .out_ready(out_ready), .out_data(od_b));
  split_fir #(.NTAP(7), .DW(8), .CW(5), .SPLIT(5), .COEFS(CB)) dut_hi (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_c),
    .in_data(in_data), .out_valid(ov_c), .out_ready(out_ready), .out_data(od_c));

  int checks = 0;
  int failures = 0;
  int ha [24];
  int hb [7];
  int xs [8192];
  int nacc = 0;
  longint qa [$];
  longint qb [$];
  longint qc [$];
  bit exp_valid = 0;
  bit stall = 0;
  longint snap_a, snap_b, snap_c;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint ref_out(input int nt, input int n);
    longint s = 0;
    for (int i = 0; i < nt; i++)
      if (n - i >= 0) s += longint'((nt == 24) ? ha[i] : hb[i]) * longint'(xs[n-i]);
    return s;
  endfunction

  task automatic cmp_out(input string tag, input longint act, inout longint q [$]);
    if (q.size() == 0) chk(0, {tag, " unexpected output"}, act, 0);
    else begin
      longint e = q.pop_front();
      chk(act == e, tag, act, e);
    end
  endtask

  task automatic cyc(input bit v, input int d, input bit r, input string tag);
    bit acc;
    // R8: valid in the cycle after acceptance
    if (exp_valid) chk(ov_a && ov_b && ov_c, "R8 out_valid after accept", longint'(ov_a), 1);
    // R9: held result unchanged during stall
    if (stall) chk(ov_a && longint'(od_a) == snap_a && longint'(od_b) == snap_b
                   && longint'(od_c) == snap_c, "R9 stall hold", longint'(od_a), snap_a);
    in_valid = v; in_data = d[7:0]; out_ready = r;
    #1;
    // R9: ready rule
    chk(rdy_a == (!ov_a || r) && rdy_b == rdy_a && rdy_c == rdy_a,
        "R9 in_ready rule", longint'(rdy_a), longint'(!ov_a || r));
    acc = v && rdy_a;
    if (ov_a && r) begin
      cmp_out({tag, " n24 s9"}, longint'(od_a), qa);
      cmp_out({tag, " n7 s1"},  longint'(od_b), qb);
      cmp_out({tag, " n7 s5"},  longint'(od_c), qc);
    end
    stall = ov_a && !r;
    snap_a = longint'(od_a); snap_b = longint'(od_b); snap_c = longint'(od_c);
    if (acc) begin
      xs[nacc] = int'(in_data);
      qa.push_back(ref_out(24, nacc));
      qb.push_back(ref_out(7, nacc));
      qc.push_back(ref_out(7, nacc));
      nacc++;
    end
    exp_valid = acc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ov_a && !ov_b && !ov_c, "R1 out_valid after reset", longint'(ov_a), 0);
    chk(rdy_a && rdy_b && rdy_c, "R1 in_ready after reset", longint'(rdy_a), 1);
    rst = 1'b0;
    nacc = 0; qa.delete(); qb.delete(); qc.delete();
    exp_valid = 0; stall = 0;
    @(negedge clk);
  endtask

  initial begin
    int hha [12] = '{1, 0, -2, -3, -1, 3, 6, 4, -4, -11, 8, 31};
    int hhb [4]  = '{-3, 5, 9, 15};
    void'($urandom(32'd2024));
    for (int k = 0; k < 24; k++) ha[k] = hha[(k < 12) ? k : 23 - k];
    for (int k = 0; k < 7; k++)  hb[k] = hhb[(k < 4) ? k : 6 - k];

    do_reset();
    // R3: impulse shows the mirrored coefficient set
    cyc(1, 1, 1, "R3 impulse");
    for (int k = 0; k < 30; k++) cyc(1, 0, 1, "R3 impulse");
    // R4 R6: sustained full scale of both signs
    for (int k = 0; k < 30; k++) cyc(1, -128, 1, "R4 R6 most negative");
    for (int k = 0; k < 30; k++) cyc(1, 127, 1, "R4 R6 most positive");
    for (int k = 0; k < 40; k++) cyc(1, (k % 2) ? 127 : -128, 1, "R6 alternating");
    for (int k = 0; k < 40; k++) cyc(1, (ha[k % 24] < 0) ? -128 : 127, 1, "R6 sign matched");
    // R10: gaps in input valid
    for (int k = 0; k < 80; k++) cyc(($urandom % 2) == 1, int'($urandom % 256), 1, "R10 gaps");
    // R9: random back-pressure
    for (int k = 0; k < 300; k++)
      cyc(($urandom % 3) != 0, int'($urandom % 256), ($urandom % 2) == 1, "R9 backpressure");
    // R2 R5 R7: random stream
    for (int k = 0; k < 1500; k++) begin
      int d = ($urandom % 16 == 0) ? -128 : int'($urandom % 256);
      cyc(($urandom % 8) != 0, d, ($urandom % 8) != 0, "R2 R5 R7 random");
    end
    // R1: mid-run reset clears history
    do_reset();
    cyc(1, 50, 1, "R1 post reset");
    for (int k = 0; k < 30; k++) cyc(1, 0, 1, "R1 post reset");
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, "R2 drain");
    chk(qa.size() == 0 && qb.size() == 0 && qc.size() == 0, "R2 all results delivered",
        longint'(qa.size()), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule